// File: doc/BRIEF.md
# Switchable Flip-Flop / Latch Cell for a Lookup-Table Pair

This block is the storage element that sits behind two lookup-table outputs, called here the even input and the odd input. A three-bit mode field chooses at run time how the pair is read. In the two flip-flop modes the even input is the data (or J) and the odd input is the gate (or K), and the stored bit changes only on a rising clock edge. In the two latch modes the even input is the data (or set) and the odd input is the gate (or reset), and the output responds at once. A passthrough mode bypasses the storage bit entirely.

The latch modes are built without a real level-sensitive latch. The output follows the inputs combinationally while the latch is open. The storage flop then captures that output on every enabled clock edge. A latch value is therefore kept only if the opening condition is still present at a clock edge.

A clock enable freezes the cell. A synchronous clear input applies to the flip-flop modes. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `lps_cell`

## Requirements
- R1: Mode code 0 is passthrough: the output equals the even input combinationally. Codes 5, 6 and 7 behave the same way.
- R2: Mode code 1 is the gated D flip-flop. On an enabled rising edge, if the odd input is 1 the output takes the even input. If the odd input is 0 the output holds.
- R3: In mode codes 1 and 2, the clear input set to 1 forces the output to 0 on the next enabled rising edge. This takes priority over the data inputs.
- R4: Mode code 2 is the JK flip-flop, with J on the even input and K on the odd input. On an enabled rising edge the pairs {J,K} give: 00 hold, 01 clear, 10 set, 11 toggle.
- R5: Mode code 3 is the gated D latch. While the odd input is 1 and the clock enable is 1, the output equals the even input with no delay. Otherwise the output shows the value captured at the last enabled edge.
- R6: Mode code 4 is the RS latch, with S on the even input and R on the odd input. {S,R} = 10 sets the output to 1 at once, 01 clears it, and 00 holds. The forbidden pair 11 drives the output to 0.
- R7: In mode codes 3 and 4 the clear input has no effect.
- R8: While the clock enable is 0, neither the stored bit nor the active mode changes. In the latch modes the output shows the stored bit.
- R9: When the mode field differs from the active mode at an enabled edge, that edge clears the stored bit and makes the new mode active. The new mode's rules apply from then on.
- R10: Asserting reset low immediately clears the stored bit and selects passthrough. After reset is released, the cell stays in reset for exactly two more rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Clock enable for the storage bit and the mode register |
| mode_i | input | 3 | Behaviour select (0 pass, 1 DFF, 2 JK, 3 D latch, 4 RS latch) |
| clr_i | input | 1 | Synchronous clear for the flip-flop modes |
| even_i | input | 1 | Even lookup-table output (D, J or S) |
| odd_i | input | 1 | Odd lookup-table output (G, K or R) |
| q_o | output | 1 | Cell output |

## Verification
Results come due at three different times:
- Passthrough results and open-latch results depend only on the present inputs.
- Flip-flop results and mode switches appear after one enabled rising edge.
- Reset release becomes visible at the third rising edge after rst_ni goes high.

The bench drives every vector at a falling edge and keeps the inputs steady across the following rising edge. It samples 1 ns after that edge, so a single sample sees both the registered effect and the combinational view of the held inputs. For the reset-release case, the checks are placed at the second, third and fourth edges after release.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int LPS_MODE_W = 3;

  typedef enum logic [LPS_MODE_W-1:0] {
    LPS_PASS = 3'd0,
    LPS_DFF  = 3'd1,
    LPS_JK   = 3'd2,
    LPS_DLAT = 3'd3,
    LPS_RS   = 3'd4
  } lps_mode_e;
endpackage

// File: rtl/lps_rst_sync.sv
module lps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/lps_next.sv
module lps_next
  import lps_pkg::*;
(
  input  logic [LPS_MODE_W-1:0] mode_i,
  input  logic                  en_i,
  input  logic                  clr_i,
  input  logic                  even_i,
  input  logic                  odd_i,
  input  logic                  state_i,
  output logic                  next_o,
  output logic                  out_o
);
  always_comb begin
    next_o = state_i;
    out_o  = state_i;
    case (mode_i)
      LPS_DFF: begin
        if (clr_i)      next_o = 1'b0;
        else if (odd_i) next_o = even_i;
      end
      LPS_JK: begin
        if (clr_i) next_o = 1'b0;
        else begin
          case ({even_i, odd_i})
            2'b01:   next_o = 1'b0;
            2'b10:   next_o = 1'b1;
            2'b11:   next_o = ~state_i;
            default: next_o = state_i;
          endcase
        end
      end
      LPS_DLAT: begin
        if (en_i && odd_i) out_o = even_i;
        next_o = out_o;
      end
      LPS_RS: begin
        if (en_i) begin
          if (odd_i)       out_o = 1'b0;
          else if (even_i) out_o = 1'b1;
        end
        next_o = out_o;
      end
      default: begin
        out_o  = even_i;
        next_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lps_store.sv
module lps_store
  import lps_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [LPS_MODE_W-1:0] mode_req_i,
  input  logic                  next_i,
  output logic [LPS_MODE_W-1:0] mode_o,
  output logic                  state_o
);
  logic [LPS_MODE_W-1:0] mode_q, mode_d;
  logic                  state_q, state_d;

  always_comb begin
    mode_d  = mode_q;
    state_d = state_q;
    if (en_i) begin
      if (mode_req_i != mode_q) begin
        mode_d  = mode_req_i;
        state_d = 1'b0;
      end else begin
        state_d = next_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= LPS_PASS;
      state_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      state_q <= state_d;
    end
  end

  assign mode_o  = mode_q;
  assign state_o = state_q;

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(state_q) && $stable(mode_q)));

  a_r9_switch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_req_i != mode_q) |=> (!state_q && mode_q == $past(mode_req_i)));
endmodule

// File: rtl/lps_cell.sv
module lps_cell
  import lps_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clk_en_i,
  input  logic [LPS_MODE_W-1:0] mode_i,
  input  logic                  clr_i,
  input  logic                  even_i,
  input  logic                  odd_i,
  output logic                  q_o
);
  logic                  rst_s_n;
  logic [LPS_MODE_W-1:0] mode_act;
  logic                  state;
  logic                  next_bit;
  logic                  out_bit;

  lps_rst_sync #(.STAGES(RST_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s_n)
  );

  lps_next u_next (
    .mode_i  (mode_act),
    .en_i    (clk_en_i),
    .clr_i   (clr_i),
    .even_i  (even_i),
    .odd_i   (odd_i),
    .state_i (state),
    .next_o  (next_bit),
    .out_o   (out_bit)
  );

  lps_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_s_n),
    .en_i       (clk_en_i),
    .mode_req_i (mode_i),
    .next_i     (next_bit),
    .mode_o     (mode_act),
    .state_o    (state)
  );

  assign q_o = out_bit;

  logic steady;
  assign steady = clk_en_i && (mode_i == mode_act);

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (steady && clr_i && (mode_act == LPS_DFF || mode_act == LPS_JK)) |=> !q_o);

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (steady && mode_act == LPS_JK && !clr_i && even_i && odd_i) |=> (q_o != $past(q_o)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (steady && mode_act == LPS_DFF && !clr_i && !odd_i) |=> $stable(q_o));

  a_r6_forbidden: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (clk_en_i && mode_act == LPS_RS && even_i && odd_i) |-> !q_o);
endmodule

// File: tb/tb_lps_cell.sv
`timescale 1ns/1ps
module tb_lps_cell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] mode;
  logic       clr, even, odd;
  logic       q;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  lps_cell dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .mode_i(mode),
    .clr_i(clr), .even_i(even), .odd_i(odd), .q_o(q)
  );

  // {mode[2:0], en, clr, even, odd, expected q after the edge}
  localparam int NV = 33;
  localparam logic [7:0] VEC [NV] = '{
    8'b000_1_0_1_0_1, 8'b000_1_0_0_0_0,                     // R1
    8'b001_1_0_1_1_0,                                       // R9
    8'b001_1_0_1_1_1, 8'b001_1_0_0_0_1,                     // R2
    8'b001_0_0_0_1_1,                                       // R8
    8'b001_1_0_0_1_0, 8'b001_1_0_1_1_1,                     // R2
    8'b001_1_1_1_1_0,                                       // R3
    8'b010_1_0_1_0_0,                                       // R9
    8'b010_1_0_1_0_1, 8'b010_1_0_0_0_1, 8'b010_1_0_1_1_0,   // R4
    8'b010_1_0_1_1_1, 8'b010_1_0_0_1_0, 8'b010_1_0_1_0_1,   // R4
    8'b010_1_1_1_0_0,                                       // R3
    8'b011_1_0_1_1_1,                                       // R9
    8'b011_1_0_1_1_1, 8'b011_1_0_0_0_1, 8'b011_1_0_0_1_0,   // R5
    8'b011_1_0_1_0_0,                                       // R5
    8'b100_1_0_1_0_1,                                       // R9
    8'b100_1_0_1_0_1, 8'b100_1_0_0_0_1,                     // R6
    8'b100_0_0_0_1_1,                                       // R8
    8'b100_1_0_0_1_0, 8'b100_1_0_1_0_1, 8'b100_1_0_1_1_0,   // R6
    8'b100_1_0_1_0_1,                                       // R6
    8'b100_1_1_0_0_1,                                       // R7
    8'b111_1_0_1_0_1, 8'b111_1_0_0_0_0                      // R1
  };
  localparam int REQ [NV] = '{1,1,9,2,2,8,2,2,3,9,4,4,4,4,4,4,3,9,5,5,5,5,9,6,6,8,6,6,6,6,7,1,1};

  task automatic check(input int req, input logic exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL R%0d: q_o=%b expected %b at %0t", req, q, exp, $time);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic e, input logic c,
                       input logic ev, input logic od);
    @(negedge clk);
    mode = m; en = e; clr = c; even = ev; odd = od;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; mode = 3'd1; clr = 1'b0; even = 1'b1; odd = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(10, 1'b1);              // R10: reset state is passthrough
    even = 1'b0;
    #1 check(10, 1'b0);              // R10
    @(negedge clk);
    rst_n = 1'b1; mode = 3'd0;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][7:5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      @(posedge clk);
      #1 check(REQ[i], VEC[i][0]);
    end

    // R10: async reset mid-run, then exact synchronized release length
    drive(3'd1, 1'b1, 1'b0, 1'b1, 1'b1);
    @(posedge clk);
    drive(3'd1, 1'b1, 1'b0, 1'b1, 1'b1);
    @(posedge clk);
    #1 check(2, 1'b1);               // R2
    @(negedge clk);
    even = 1'b0; rst_n = 1'b0;
    #1 check(10, 1'b0);              // R10: cleared, passthrough of 0
    even = 1'b1;
    #1 check(10, 1'b1);              // R10: passthrough of 1
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check(10, 1'b1);              // R10: still held in reset at edge 2
    @(posedge clk);
    #1 check(9, 1'b0);               // R9: first live edge switches mode, clears
    @(posedge clk);
    #1 check(2, 1'b1);               // R2: loads even input

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule